// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a byte-addressed serial EEPROM that sits on a two-wire I2C bus as a slave. It watches the clock and data lines through synchronisers, decodes START and STOP conditions, and answers to a control byte. That byte carries a fixed device code, a half-select bit, two chip-select bits compared against strap pins, and a read/write flag. After the control byte a master sends two address bytes and any number of data bytes. Data bytes are gathered in a 64-byte page buffer and written to the array only after STOP.

Each committed write starts an internal write cycle of `WR_CYCLES` clocks. During that cycle the block does not acknowledge its control byte, so a master can poll for completion. Reads return the byte at a 15-bit internal address counter and then advance it. The counter wraps inside the half of the address space picked by the half-select bit. The array depth is a parameter so that simulations can use a small memory. SDA is never driven high: the only output is an enable that pulls the line low.

Top module: `eep_i2c_slave`

## Requirements
- R1: During reset and after it, `sda_oe_o` is low. It is also low in the cycle after any STOP.
- R2: The control byte is decoded as bits 7:4 = device code (`DEV_CODE`, default 4'b1010), bit 3 = half select, bits 2:1 = chip select, bit 0 = R/W (1 = read). If the device code or the chip select (compared with `strap_i`) does not match, the byte gets no ACK and the slave ignores the bus until the next START.
- R3: The slave pulls SDA low during the 9th clock of every byte it accepts. Its SDA drive changes only while SCL is low, except for the release at START or STOP.
- R4: A write sends the control byte, then a high address byte whose bits 6:0 become address bits 14:8, then a low address byte for bits 7:0. The half-select bit supplies address bit 15. Both address bytes are acknowledged.
- R5: A current-address read returns the byte at {half select, counter} and then increments the counter by one.
- R6: Data bytes are stored at the counter's low 6 bits, which step by one and wrap within the same 64-byte page, so a 65th byte overwrites the first. The page is written to the array only after STOP.
- R7: A STOP after at least one data byte starts a write cycle of `WR_CYCLES` clocks. While it runs, a control byte addressed to the slave is not acknowledged. Afterwards it is acknowledged again.
- R8: A random read is a write of the address bytes only, followed by a repeated START and a read control byte. It returns the byte at the address that was sent.
- R9: In a sequential read, every master ACK makes the slave send the next byte. The 15-bit counter wraps 0x7FFF to 0x0000 in the lower half and 0xFFFF to 0x8000 in the upper half.
- R10: After a master NACK the slave releases SDA and ignores further clocks until START or STOP. A further byte clocked by the master therefore reads 0xFF.
- R11: A write that sends no data byte before STOP starts no write cycle, so the next control byte is acknowledged at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired-AND value) |
| strap_i | input | 2 | Chip-select strap pins matched against control bits 2:1 |
| sda_oe_o | output | 1 | When high, pulls SDA low (open-drain enable) |

## Verification
The bench is an open-drain bus master that drives the bus like a real master. Control bytes with a wrong device code and with a wrong chip select are sent next to matching ones, which shows that the address decode checks both fields. Reads are tried as random, current-address and sequential transfers. The sequential runs start at 0x7FFF and 0xFFFF, so a wrong wrap target can be seen in the second byte. A 66-byte page write shows the in-page wrap, and an immediate poll, a late poll and an address-only write tell a live write cycle apart from an idle device.

// File: rtl/eep_pkg.sv
package eep_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_CTRL, S_AHI, S_ALO, S_WDATA, S_READ, S_WAIT
  } eep_st_t;

  typedef enum logic [1:0] {
    PH_BITS, PH_SACK, PH_MACK
  } eep_ph_t;

  // control byte matches device code and strap pins
  function automatic logic eep_ctrl_match(input logic [7:0] b,
                                          input logic [3:0] code,
                                          input logic [1:0] strap);
    return (b[7:4] == code) && (b[2:1] == strap);
  endfunction

  // counter advance: 15 bits, so it stays inside its half
  function automatic logic [14:0] eep_ctr_step(input logic [14:0] c);
    return c + 15'd1;
  endfunction

  // fold a 16-bit byte address onto an array of 2**aw bytes:
  // bit 15 lands on the top index bit, low aw-1 bits are kept
  function automatic logic [15:0] eep_fold(input logic [15:0] a,
                                           input int unsigned aw);
    logic [15:0] m;
    m = (16'd1 << (aw - 1)) - 16'd1;
    return (a & m) | (16'(a[15]) << (aw - 1));
  endfunction

endpackage

// File: rtl/eep_line_mon.sv
module eep_line_mon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  localparam int D = SYNC_STAGES + 1;

  logic [D-1:0] scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[D-2:0], scl_i};
      sda_q <= {sda_q[D-2:0], sda_i};
    end
  end

  assign scl_s     = scl_q[D-2];
  assign sda_s     = sda_q[D-2];
  assign scl_rise  =  scl_q[D-2] & ~scl_q[D-1];
  assign scl_fall  = ~scl_q[D-2] &  scl_q[D-1];
  assign start_evt =  scl_q[D-2] &  scl_q[D-1] & ~sda_q[D-2] &  sda_q[D-1];
  assign stop_evt  =  scl_q[D-2] &  scl_q[D-1] &  sda_q[D-2] & ~sda_q[D-1];
endmodule

// File: rtl/eep_store.sv
module eep_store
  import eep_pkg::*;
#(
  parameter int MEM_AW    = 10,
  parameter int PAGE_AW   = 6,
  parameter int WR_CYCLES = 250000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pb_we,
  input  logic [PAGE_AW-1:0] pb_off,
  input  logic [7:0]         pb_din,
  input  logic               pb_clr,
  input  logic               commit_go,
  input  logic [15:0]        commit_addr,
  input  logic [15:0]        rd_addr,
  output logic [7:0]         rd_data,
  output logic               busy
);
  localparam int DEPTH = 1 << MEM_AW;
  localparam int PAGE  = 1 << PAGE_AW;
  localparam int TW    = $clog2(WR_CYCLES + 1);

  logic [7:0]         mem  [DEPTH];
  logic [7:0]         pbuf [PAGE];
  logic [PAGE-1:0]    pval;
  logic [TW-1:0]      tmr;
  logic               walking;
  logic [PAGE_AW-1:0] k;
  logic [15:0]        base;
  logic [15:0]        walk_addr;
  logic [MEM_AW-1:0]  walk_idx, rd_idx;

  assign walk_addr = {base[15:PAGE_AW], k};
  assign walk_idx  = MEM_AW'(eep_fold(walk_addr, MEM_AW));
  assign rd_idx    = MEM_AW'(eep_fold(rd_addr, MEM_AW));
  assign rd_data   = mem[rd_idx];
  assign busy      = (tmr != '0);

  always_ff @(posedge clk) begin
    if (walking && pval[k]) mem[walk_idx] <= pbuf[k];
    if (pb_we) pbuf[pb_off] <= pb_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr     <= '0;
      walking <= 1'b0;
      k       <= '0;
      base    <= '0;
      pval    <= '0;
    end else if (commit_go) begin
      tmr     <= TW'(WR_CYCLES);
      walking <= 1'b1;
      k       <= '0;
      base    <= commit_addr;
    end else begin
      if (busy) tmr <= tmr - 1'b1;
      if (walking) begin
        pval[k] <= 1'b0;
        k       <= k + 1'b1;
        if (k == PAGE_AW'(PAGE - 1)) walking <= 1'b0;
      end else begin
        if (pb_clr) pval <= '0;
        if (pb_we)  pval[pb_off] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/eep_i2c_slave.sv
module eep_i2c_slave
  import eep_pkg::*;
#(
  parameter logic [3:0] DEV_CODE  = 4'b1010,
  parameter int         MEM_AW    = 10,
  parameter int         PAGE_AW   = 6,
  parameter int         WR_CYCLES = 250000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] strap_i,
  output logic       sda_oe_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;

  eep_line_mon #(.SYNC_STAGES(2)) mon_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  eep_st_t     st;
  eep_ph_t     ph;
  logic [3:0]  cnt;
  logic [7:0]  sh;
  logic        mack, blk, wr_pend;
  logic [6:0]  hi;
  logic [14:0] ctr;
  logic        busy;
  logic [7:0]  rd_data;

  // named internal events
  logic rx_st, in_ctrl, byte_done, load_tx, ctr_step, commit_go, addr_hit, pb_we;

  assign rx_st     = (st == S_CTRL) || (st == S_AHI) || (st == S_ALO) || (st == S_WDATA);
  assign in_ctrl   = (st == S_CTRL);
  assign byte_done = scl_fall && (ph == PH_BITS) && rx_st && (cnt == 4'd8);
  assign load_tx   = scl_fall && (st == S_READ) &&
                     ((ph == PH_SACK) || ((ph == PH_MACK) && mack));
  assign ctr_step  = load_tx;
  assign commit_go = stop_evt && wr_pend;
  assign addr_hit  = eep_ctrl_match(sh, DEV_CODE, strap_i) && !busy;
  assign pb_we     = byte_done && (st == S_WDATA);

  eep_store #(.MEM_AW(MEM_AW), .PAGE_AW(PAGE_AW), .WR_CYCLES(WR_CYCLES)) store_i (
    .clk(clk), .rst_n(rst_n),
    .pb_we(pb_we), .pb_off(ctr[PAGE_AW-1:0]), .pb_din(sh), .pb_clr(start_evt),
    .commit_go(commit_go), .commit_addr({blk, ctr[14:PAGE_AW], {PAGE_AW{1'b0}}}),
    .rd_addr({blk, ctr}), .rd_data(rd_data), .busy(busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= PH_BITS; cnt <= '0; sh <= '0; mack <= 1'b0;
      blk <= 1'b0; hi <= '0; ctr <= '0; wr_pend <= 1'b0; sda_oe_o <= 1'b0;
    end else if (start_evt) begin
      st <= S_CTRL; ph <= PH_BITS; cnt <= '0; sda_oe_o <= 1'b0; wr_pend <= 1'b0;
    end else if (stop_evt) begin
      st <= S_IDLE; ph <= PH_BITS; cnt <= '0; sda_oe_o <= 1'b0; wr_pend <= 1'b0;
    end else begin
      if (scl_rise) begin
        if (ph == PH_BITS && (rx_st || st == S_READ) && cnt != 4'd8) begin
          if (rx_st) sh <= {sh[6:0], sda_s};
          cnt <= cnt + 4'd1;
        end
        if (ph == PH_MACK) mack <= ~sda_s;
      end
      if (scl_fall) begin
        if (byte_done) begin
          ph       <= PH_SACK;
          sda_oe_o <= 1'b1;
          case (st)
            S_CTRL: begin
              if (addr_hit) begin
                blk <= sh[3];
                st  <= sh[0] ? S_READ : S_AHI;
              end else begin
                st <= S_WAIT; ph <= PH_BITS; sda_oe_o <= 1'b0;
              end
            end
            S_AHI: begin hi <= sh[6:0]; st <= S_ALO; end
            S_ALO: begin ctr <= {hi, sh}; st <= S_WDATA; end
            S_WDATA: begin
              ctr[PAGE_AW-1:0] <= ctr[PAGE_AW-1:0] + 1'b1;
              wr_pend <= 1'b1;
            end
            default: ;
          endcase
        end else if (load_tx) begin
          sh <= rd_data; sda_oe_o <= ~rd_data[7];
          ctr <= eep_ctr_step(ctr); ph <= PH_BITS; cnt <= '0;
        end else if (ph == PH_SACK) begin
          ph <= PH_BITS; cnt <= '0; sda_oe_o <= 1'b0;
        end else if (ph == PH_MACK) begin
          st <= S_WAIT; ph <= PH_BITS; sda_oe_o <= 1'b0;
        end else if (ph == PH_BITS && st == S_READ) begin
          if (cnt == 4'd8) begin
            ph <= PH_MACK; sda_oe_o <= 1'b0;
          end else begin
            sh <= {sh[6:0], 1'b0}; sda_oe_o <= ~sh[6];
          end
        end
      end
    end
  end
endmodule

// File: rtl/eep_i2c_slave_chk.sv
module eep_i2c_slave_chk #(
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input logic        clk,
  input logic        rst_n,
  input logic        sda_oe,
  input logic        scl_s,
  input logic        start_evt,
  input logic        stop_evt,
  input logic        byte_done,
  input logic        in_ctrl,
  input logic [7:0]  rx_byte,
  input logic [1:0]  strap,
  input logic        busy,
  input logic [14:0] ctr,
  input logic        ctr_step
);
  a_r1_release_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);

  a_r3_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(start_evt) && !$past(stop_evt)) |-> !scl_s);

  a_r2_no_ack_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && in_ctrl && ((rx_byte[7:4] != DEV_CODE) || (rx_byte[2:1] != strap)))
      |=> !sda_oe);

  a_r7_busy_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && in_ctrl && busy) |=> !sda_oe);

  a_r7_busy_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_evt));

  a_r9_counter_step: assert property (@(posedge clk) disable iff (!rst_n)
    ctr_step |=> (ctr == $past(ctr) + 15'd1));
endmodule

bind eep_i2c_slave eep_i2c_slave_chk #(.DEV_CODE(DEV_CODE)) chk_i (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe_o), .scl_s(scl_s),
  .start_evt(start_evt), .stop_evt(stop_evt), .byte_done(byte_done),
  .in_ctrl(in_ctrl), .rx_byte(sh), .strap(strap_i), .busy(busy),
  .ctr(ctr), .ctr_step(ctr_step)
);

// File: tb/eep_i2c_slave_tb_top.sv
module eep_i2c_slave_tb_top;
  localparam int         WR    = 400;
  localparam int         Q     = 6;
  localparam logic [1:0] STRAP = 2'b10;
  localparam logic [3:0] DEV   = 4'b1010;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_low = 1'b0;
  logic oe, sda_bus;
  assign sda_bus = !(m_low || oe);
  always #5 clk = ~clk;

  eep_i2c_slave #(.DEV_CODE(DEV), .MEM_AW(10), .PAGE_AW(6), .WR_CYCLES(WR)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .strap_i(STRAP), .sda_oe_o(oe)
  );

  int total = 0, bad = 0;
  bit finished = 1'b0;
  logic [7:0] model [int];
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] act_q [$];

  task automatic check(input bit ok, input string tag, input int act, input int exp,
                       input string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // scoreboard monitor: compares bytes as the master receives them
  initial begin
    logic [7:0] a, e;
    string t;
    forever begin
      @(negedge clk);
      while (act_q.size() > 0) begin
        a = act_q.pop_front();
        if (exp_q.size() == 0) check(1'b0, "R5", a, 0, "unexpected byte");
        else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(a === e, t, a, e, "read byte");
        end
      end
    end
  end

  task automatic expect_byte(input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 1'b0; qw(); scl = 1'b1; qw(); m_low = 1'b1; qw(); scl = 1'b0; qw();
  endtask

  task automatic bus_stop();
    m_low = 1'b1; qw(); scl = 1'b1; qw(); m_low = 1'b0; qw();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0; qw();
    end
    m_low = 1'b0; qw(); scl = 1'b1; qw(); ack = !sda_bus; qw(); scl = 1'b0; qw();
  endtask

  task automatic recv_byte(input bit give_ack);
    logic [7:0] b;
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      qw(); scl = 1'b1; qw(); b[i] = sda_bus; qw(); scl = 1'b0; qw();
    end
    act_q.push_back(b);
    m_low = give_ack; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0; qw(); m_low = 1'b0;
  endtask

  function automatic logic [7:0] ctrl(input logic half, input logic rd);
    return {DEV, half, STRAP, rd};
  endfunction

  task automatic set_addr(input logic [15:0] a);
    bit ack;
    bus_start();
    send_byte(ctrl(a[15], 1'b0), ack); check(ack, "R3", ack, 1, "control ack");
    send_byte({1'b0, a[14:8]}, ack);   check(ack, "R4", ack, 1, "high address ack");
    send_byte(a[7:0], ack);            check(ack, "R4", ack, 1, "low address ack");
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d[$]);
    bit ack;
    logic [15:0] p;
    set_addr(a);
    p = a;
    foreach (d[i]) begin
      send_byte(d[i], ack); check(ack, "R6", ack, 1, "data ack");
      model[int'(p)] = d[i];
      p[5:0] = p[5:0] + 6'd1;
    end
    bus_stop();
    repeat (WR + 60) @(negedge clk);
  endtask

  task automatic read_seq(input logic [15:0] a, input int n, input string t, input bit rnd);
    bit ack;
    logic [15:0] p;
    if (rnd) set_addr(a);
    bus_start();
    send_byte(ctrl(a[15], 1'b1), ack); check(ack, "R5", ack, 1, "read control ack");
    p = a;
    for (int i = 0; i < n; i++) begin
      expect_byte(model[int'(p)], t);
      recv_byte(i != n - 1);
      p = {p[15], p[14:0] + 15'd1};
    end
    bus_stop();
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R1: actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] d [$];
    repeat (4) @(negedge clk);
    check(oe == 1'b0, "R1", oe, 0, "oe in reset");
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(oe == 1'b0, "R1", oe, 0, "oe after reset");

    // R2: wrong device code, then wrong chip select
    bus_start(); send_byte(8'hB4, ack); check(!ack, "R2", ack, 0, "wrong code"); bus_stop();
    bus_start(); send_byte({DEV, 1'b0, ~STRAP, 1'b0}, ack);
    check(!ack, "R2", ack, 0, "wrong strap"); bus_stop();

    // two-byte write, immediate poll must be refused (R7)
    set_addr(16'h0012);
    send_byte(8'hA5, ack); check(ack, "R6", ack, 1, "data ack");
    send_byte(8'h5A, ack); check(ack, "R6", ack, 1, "data ack");
    model[16'h0012] = 8'hA5; model[16'h0013] = 8'h5A;
    bus_stop();
    bus_start(); send_byte(ctrl(1'b0, 1'b0), ack);
    check(!ack, "R7", ack, 0, "poll during write cycle"); bus_stop();
    repeat (WR + 60) @(negedge clk);
    bus_start(); send_byte(ctrl(1'b0, 1'b0), ack);
    check(ack, "R7", ack, 1, "poll after write cycle"); bus_stop();

    read_seq(16'h0012, 1, "R8", 1'b1);
    read_seq(16'h0013, 1, "R5", 1'b0);

    // page write of 66 bytes: last two wrap onto the page start
    d = {};
    for (int i = 0; i < 66; i++) d.push_back(8'(i * 7 + 3));
    do_write(16'h0040, d);
    read_seq(16'h0040, 64, "R6", 1'b1);

    // wrap within upper and lower halves
    do_write(16'hFFFF, '{8'h3C});
    do_write(16'h8000, '{8'hC3});
    read_seq(16'hFFFF, 2, "R9", 1'b1);
    do_write(16'h7FFF, '{8'h77});
    do_write(16'h0000, '{8'h11});
    read_seq(16'h7FFF, 2, "R9", 1'b1);

    // address-only write: no write cycle (R11)
    set_addr(16'h0040); bus_stop();
    bus_start(); send_byte(ctrl(1'b0, 1'b0), ack);
    check(ack, "R11", ack, 1, "ack right after address-only write"); bus_stop();

    // current read then master NACK; extra byte sees released line (R10)
    bus_start(); send_byte(ctrl(1'b0, 1'b1), ack);
    check(ack, "R5", ack, 1, "read control ack");
    expect_byte(model[16'h0040], "R5");
    recv_byte(1'b0);
    expect_byte(8'hFF, "R10");
    recv_byte(1'b0);
    bus_stop();
    repeat (4) @(negedge clk);
    check(oe == 1'b0, "R1", oe, 0, "oe after stop");

    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R5", exp_q.size(), 0, "bytes left unread");
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule